// File: doc/BRIEF.md
# Converter Result Holding Registers with Read Interlock

This block keeps the most recent analog-to-digital sample in byte-wide result registers that a processor reads over a simple bus. It ensures that a two-byte read of a 10-bit sample returns both halves of the same sample. A one-cycle `conv_done` pulse delivers a new 10-bit value on `conv_data`. The `mode_10bit` input selects how the bytes are presented and whether the interlock is active. The block also holds a byte-wide clock and mode configuration register, and it drives each field of that register onto its own output.

The interlock is a two-state machine. In `TRACKING`, every completed conversion is loaded. The transition `TRACKING -> FROZEN` (named *hi_read*) happens when the high byte is read in 10-bit mode. In `FROZEN`, completed conversions are discarded. The transition `FROZEN -> TRACKING` (named *lo_read*) happens when the low byte is read. A second transition to `TRACKING` (named *mode8*) happens whenever `mode_10bit` is low, because 8-bit operation has no interlock.

Bus map: address 0 is the high byte, address 1 is the low byte, address 2 is the configuration register, and address 3 is unused. A read is any cycle with `bus_sel` high and `bus_wr` low. Read data is combinational in the same cycle.

Top module: `adc_result_latch`

## Requirements
- R1: After reset, every readable location returns 0x00, all configuration field outputs are 0, and the machine is in `TRACKING`.
- R2: A conversion accepted on `conv_done` is visible on the bus from the following cycle. It is accepted whenever the machine is in `TRACKING` and no 10-bit high-byte read happens in that cycle.
- R3: In 10-bit mode, address 0 returns result bits 9..8 on data bits 1..0, and data bits 7..2 read as 0.
- R4: In 8-bit mode, address 0 reads as 0x00.
- R5: Address 1 returns result bits 7..0 on data bits 7..0. Address 3 reads as 0x00.
- R6: In 10-bit mode, a high-byte read moves the machine to `FROZEN`. A conversion completing in that same cycle is discarded.
- R7: While the machine is `FROZEN`, completed conversions are discarded and the result registers keep their value.
- R8: A low-byte read returns the machine to `TRACKING`. A conversion completing in the same cycle as that read is accepted.
- R9: In 8-bit mode, reads have no interlock effect, every conversion is accepted, and a freeze left over from 10-bit mode is dropped.
- R10: Address 2 is fully readable and writable. From bit 7 down to bit 0 it holds: low-power flag, 2-bit divider select, input clock select, 2-bit mode field, long-sample flag, and asynchronous clock enable. Each field appears on its own output.
- R11: Writes to addresses 0, 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_10bit | input | 1 | 1 selects 10-bit results with interlock; 0 selects 8-bit |
| conv_done | input | 1 | One-cycle pulse: a conversion finished |
| conv_data | input | 10 | Result carried by `conv_done` |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cfg_low_power | output | 1 | Configuration bit 7 |
| cfg_div_sel | output | 2 | Configuration bits 6..5 |
| cfg_clk_src | output | 1 | Configuration bit 4 |
| cfg_mode | output | 2 | Configuration bits 3..2 |
| cfg_long_sample | output | 1 | Configuration bit 1 |
| cfg_async_clk_en | output | 1 | Configuration bit 0 |

## Verification
Conversion completion can fall in the same cycle as a bus read, which decides whether the interlock keeps a sample or drops it. The bench provokes both critical collisions. It pulses `conv_done` together with a 10-bit high-byte read, where the sample must be dropped. It also pulses `conv_done` together with the low-byte read that releases a freeze, where the sample must be kept. Randomized traffic then overlaps the two freely. A behavioural model predicts the bus data on every cycle, and the bench judges the result by what the following reads return.

// File: rtl/adc_rl_pkg.sv
package adc_rl_pkg;
    localparam int RES_W  = 10;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int HI_W   = RES_W - BYTE_W;

    localparam logic [ADDR_W-1:0] ADDR_HI  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LO  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd2;

    typedef enum logic {
        TRACKING = 1'b0,
        FROZEN   = 1'b1
    } lock_state_t;

    typedef struct packed {
        logic       low_power;
        logic [1:0] div_sel;
        logic       clk_src;
        logic [1:0] mode;
        logic       long_sample;
        logic       async_clk_en;
    } cfg_t;
endpackage

// File: rtl/adc_rl_freeze_fsm.sv
module adc_rl_freeze_fsm
    import adc_rl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_10bit,
    input  logic rd_hi,
    input  logic rd_lo,
    input  logic conv_done,
    output logic frozen,
    output logic xfer
);
    lock_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!mode_10bit) begin
            state_d = TRACKING;                  // mode8
        end else begin
            unique case (state_q)
                TRACKING: if (rd_hi) state_d = FROZEN;   // hi_read
                FROZEN:   if (rd_lo) state_d = TRACKING; // lo_read
                default:  state_d = TRACKING;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRACKING;
        else        state_q <= state_d;
    end

    always_comb begin
        frozen = (state_q == FROZEN);
        xfer   = 1'b0;
        if (conv_done) begin
            if (!mode_10bit) begin
                xfer = 1'b1;
            end else begin
                unique case (state_q)
                    TRACKING: xfer = !rd_hi;
                    FROZEN:   xfer = rd_lo;
                    default:  xfer = 1'b0;
                endcase
            end
        end
    end

    // R6
    freeze_on_hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_10bit && rd_hi) |=> frozen);
    // R8
    release_on_lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> !frozen);
endmodule

// File: rtl/adc_rl_result_reg.sv
module adc_rl_result_reg
    import adc_rl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/adc_rl_cfg_reg.sv
module adc_rl_cfg_reg
    import adc_rl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg <= '0;
        else if (wr_en) cfg <= cfg_t'(wdata);
    end
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
    import adc_rl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_10bit,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              cfg_low_power,
    output logic [1:0]        cfg_div_sel,
    output logic              cfg_clk_src,
    output logic [1:0]        cfg_mode,
    output logic              cfg_long_sample,
    output logic              cfg_async_clk_en
);
    logic             rd_hi, rd_lo, cfg_wr, frozen, xfer;
    logic [RES_W-1:0] result;
    cfg_t             cfg;

    assign rd_hi  = bus_sel && !bus_wr && (bus_addr == ADDR_HI);
    assign rd_lo  = bus_sel && !bus_wr && (bus_addr == ADDR_LO);
    assign cfg_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_CFG);

    adc_rl_freeze_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .mode_10bit(mode_10bit),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .conv_done(conv_done),
        .frozen(frozen), .xfer(xfer)
    );

    adc_rl_result_reg i_res (
        .clk(clk), .rst_n(rst_n), .load(xfer), .din(conv_data), .dout(result)
    );

    adc_rl_cfg_reg i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(bus_wdata), .cfg(cfg)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_HI:  if (mode_10bit) bus_rdata[HI_W-1:0] = result[RES_W-1:BYTE_W];
            ADDR_LO:  bus_rdata = result[BYTE_W-1:0];
            ADDR_CFG: bus_rdata = cfg;
            default:  bus_rdata = '0;
        endcase
    end

    assign cfg_low_power    = cfg.low_power;
    assign cfg_div_sel      = cfg.div_sel;
    assign cfg_clk_src      = cfg.clk_src;
    assign cfg_mode         = cfg.mode;
    assign cfg_long_sample  = cfg.long_sample;
    assign cfg_async_clk_en = cfg.async_clk_en;

    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_10bit && frozen && !rd_lo) |=> $stable(result));
    // R9
    byte8_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_10bit && conv_done) |=> (result == $past(conv_data)));
    // R4
    hi_zero_8bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_10bit && bus_addr == ADDR_HI) |-> (bus_rdata == '0));
endmodule

// File: tb/test_adc_result_latch.sv
`timescale 1ns/1ps
module test_adc_result_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_10bit = 1'b1;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cfg_low_power, cfg_clk_src, cfg_long_sample, cfg_async_clk_en;
    logic [1:0] cfg_div_sel, cfg_mode;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    int   m_res = 0;
    bit   m_frz = 1'b0;
    logic [7:0] m_cfg = 8'h00;

    always #4 clk = ~clk;

    adc_result_latch i_adc_result_latch (
        .clk(clk), .rst_n(rst_n), .mode_10bit(mode_10bit),
        .conv_done(conv_done), .conv_data(conv_data),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_low_power(cfg_low_power), .cfg_div_sel(cfg_div_sel),
        .cfg_clk_src(cfg_clk_src), .cfg_mode(cfg_mode),
        .cfg_long_sample(cfg_long_sample), .cfg_async_clk_en(cfg_async_clk_en)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a, input bit m10);
        case (a)
            2'd0:    return m10 ? 8'((m_res >> 8) & 3) : 8'h00;
            2'd1:    return 8'(m_res & 255);
            2'd2:    return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One bus cycle: drive, compare at mid-cycle, advance model at the edge.
    task automatic cyc(input bit sel, input bit wr, input logic [1:0] a,
                       input logic [7:0] wd, input bit cd, input logic [9:0] cdat,
                       input bit m10, input string tag);
        bit   rhi, rlo, xfer;
        string req;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        conv_done = cd; conv_data = cdat; mode_10bit = m10;
        #1;
        case (a)
            2'd0:    req = m10 ? "R3" : "R4";
            2'd1:    req = "R5";
            2'd2:    req = "R10";
            default: req = "R5";
        endcase
        check({tag, "/", req}, bus_rdata, exp_read(a, m10));
        check({tag, "/R10 fields"},
              {cfg_low_power, cfg_div_sel, cfg_clk_src, cfg_mode,
               cfg_long_sample, cfg_async_clk_en}, m_cfg);
        @(posedge clk);
        rhi  = sel && !wr && a == 2'd0;
        rlo  = sel && !wr && a == 2'd1;
        xfer = cd && (!m10 || (!m_frz && !rhi) || (m_frz && rlo));
        if (xfer) m_res = int'(cdat);
        if (!m10)      m_frz = 1'b0;
        else if (rlo)  m_frz = 1'b0;
        else if (rhi)  m_frz = 1'b1;
        if (sel && wr && a == 2'd2) m_cfg = wd;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input bit m10, input string tag);
        cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 10'h0, m10, tag);
    endtask

    task automatic conv(input logic [9:0] d, input bit m10, input string tag);
        cyc(1'b0, 1'b0, 2'd3, 8'h00, 1'b1, d, m10, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int a = 0; a < 4; a++) rd(2'(a), 1'b1, "R1");

        // R2: plain transfer, visible next cycle
        conv(10'h2A5, 1'b1, "R2");
        rd(2'd1, 1'b1, "R2");
        // R6: high read freezes
        rd(2'd0, 1'b1, "R6");
        // R7: conversions while frozen dropped
        conv(10'h155, 1'b1, "R7");
        conv(10'h0F0, 1'b1, "R7");
        rd(2'd0, 1'b1, "R7");
        rd(2'd1, 1'b1, "R8");
        // R6: conversion in the same cycle as high read is dropped
        cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 10'h0FF, 1'b1, "R6");
        rd(2'd0, 1'b1, "R6");
        // R8: conversion in the same cycle as releasing low read is kept
        cyc(1'b1, 1'b0, 2'd1, 8'h00, 1'b1, 10'h3C3, 1'b1, "R8");
        rd(2'd0, 1'b1, "R8");
        rd(2'd1, 1'b1, "R8");
        conv(10'h111, 1'b1, "R2");
        rd(2'd1, 1'b1, "R2");

        // R9: 8-bit mode, no interlock, leftover freeze dropped
        rd(2'd0, 1'b1, "R9");
        rd(2'd0, 1'b0, "R9");
        conv(10'h1EE, 1'b0, "R9");
        rd(2'd1, 1'b0, "R9");
        rd(2'd0, 1'b0, "R9");
        cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 10'h2D7, 1'b0, "R9");
        conv(10'h0AB, 1'b0, "R9");
        rd(2'd1, 1'b0, "R9");
        rd(2'd0, 1'b1, "R9");

        // R10: configuration register
        cyc(1'b1, 1'b1, 2'd2, 8'hA5, 1'b0, 10'h0, 1'b1, "R10");
        rd(2'd2, 1'b1, "R10");
        cyc(1'b1, 1'b1, 2'd2, 8'h5A, 1'b0, 10'h0, 1'b1, "R10");
        rd(2'd2, 1'b1, "R10");

        // R11: writes to other addresses ignored
        rd(2'd1, 1'b1, "R11");
        cyc(1'b1, 1'b1, 2'd0, 8'hFF, 1'b0, 10'h0, 1'b1, "R11");
        cyc(1'b1, 1'b1, 2'd1, 8'hFF, 1'b0, 10'h0, 1'b1, "R11");
        cyc(1'b1, 1'b1, 2'd3, 8'hFF, 1'b0, 10'h0, 1'b1, "R11");
        for (int a = 0; a < 4; a++) rd(2'(a), 1'b1, "R11");

        // mixed random traffic: collisions of conversions and reads
        for (int i = 0; i < 2000; i++) begin
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 5) == 0),
                2'($urandom), 8'($urandom), 1'($urandom_range(0, 2) == 0),
                10'($urandom), 1'($urandom_range(0, 7) != 0), "R2 mix");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule